// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block derives the serial clock for a flash shift engine from the system clock. A free-running counter steps from zero up to a programmed terminal count and wraps, which sets the serial period to the terminal count plus one system cycles. Two further programmed counts, one for the high transition and one for the low transition, place the edges of the serial clock anywhere inside that period. Duty cycle and edge placement are therefore set separately from the period. For a balanced clock with ratio N, the terminal count is N-1, the high point is N/2-1 and the low point is N-1.

Alongside the serial clock, the block produces a one-cycle strobe on each rising and each falling serial edge, aligned with the new clock level, for the shift logic to use. A bypass input makes the serial clock follow the system clock directly. While the engine is idle, the serial clock is held low and the counter is parked at zero, so every transaction starts at the same phase. The divider settings must stay constant while a transaction is running.

Top module: `sck_divider`

## Requirements
- R1: After reset, sckOut, riseStb and fallStb are all low.
- R2: While runEn is high and bypassEn is low, the internal count steps 0, 1, ..., periodCnt and then returns to 0. With distinct, in-range transition points, sckOut repeats every periodCnt+1 system cycles.
- R3: sckOut goes high after the first clock edge at which the count equals riseAt. It goes low after the first edge at which the count equals fallAt. The first active edge of a transaction sees count 0.
- R4: riseStb is high for exactly the first cycle in which sckOut is high after being low. fallStb is high for exactly the first cycle in which sckOut is low after being high. Outside bypass the two strobes are never high together.
- R5: When riseAt equals fallAt, each match inverts sckOut, giving a serial period of 2*(periodCnt+1) cycles.
- R6: A transition point greater than periodCnt never matches, so sckOut makes no transition of that kind.
- R7: With runEn low, one edge later sckOut, riseStb and fallStb are low and the count is zero. A new transaction restarts from count 0, whatever the phase at which the previous one stopped.
- R8: With runEn and bypassEn both high, sckOut equals the system clock and both strobes are high. With runEn low, sckOut is low even if bypassEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | High while a transaction is in progress |
| bypassEn | input | 1 | Serial clock follows the system clock |
| periodCnt | input | CW (6) | Terminal count, the divide ratio minus one |
| riseAt | input | CW (6) | Count at which the serial clock goes high |
| fallAt | input | CW (6) | Count at which the serial clock goes low |
| sckOut | output | 1 | Serial clock |
| riseStb | output | 1 | One-cycle strobe on a rising serial edge |
| fallStb | output | 1 | One-cycle strobe on a falling serial edge |

## Verification
Three events can fall in the same cycle: the counter wrap, the high-point match and the low-point match. The collision that needs a rule is the one where both transition points match the count at once. The bench provokes every such coincidence by sweeping all terminal counts 0 to 7 against all high and low points 0 to 7. This covers equal points, points on the wrap value and points beyond the period. Each cycle's level and strobes are compared against an arithmetic model of the rules. Separate period measurements confirm a period of N+1 cycles with distinct points and 2*(N+1) cycles with equal points.

// File: rtl/sck_divider_pkg.sv
package sck_divider_pkg;

  // strobes from counter control to clock datapath
  typedef struct packed {
    logic idle;     // hold divider parked
    logic wrap;     // counter at terminal count
    logic hitRise;  // counter at high point
    logic hitFall;  // counter at low point
  } divCtl_t;

endpackage

// File: rtl/sck_divider_ctl.sv
module sck_divider_ctl
  import sck_divider_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic          bypassEn,
  input  logic [CW-1:0] periodCnt,
  input  logic [CW-1:0] riseAt,
  input  logic [CW-1:0] fallAt,
  output divCtl_t       ctl
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic          active;

  assign active = runEn && !bypassEn;

  always_comb begin
    ctl.idle    = !active;
    ctl.wrap    = active && (cnt == periodCnt);
    ctl.hitRise = active && (cnt == riseAt);
    ctl.hitFall = active && (cnt == fallAt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.idle || ctl.wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_ONE;
    end
  end

endmodule

// File: rtl/sck_divider_dp.sv
module sck_divider_dp
  import sck_divider_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bypassMode,
  input  divCtl_t ctl,
  output logic    sckOut,
  output logic    riseStb,
  output logic    fallStb
);

  logic sckQ;
  logic riseQ;
  logic fallQ;
  logic sckNext;

  always_comb begin
    unique case ({ctl.hitRise, ctl.hitFall})
      2'b11:   sckNext = !sckQ;
      2'b10:   sckNext = 1'b1;
      2'b01:   sckNext = 1'b0;
      default: sckNext = sckQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ  <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else if (ctl.idle) begin
      sckQ  <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      sckQ  <= sckNext;
      riseQ <= sckNext && !sckQ;
      fallQ <= !sckNext && sckQ;
    end
  end

  assign sckOut  = bypassMode ? clk  : sckQ;
  assign riseStb = bypassMode ? 1'b1 : riseQ;
  assign fallStb = bypassMode ? 1'b1 : fallQ;

endmodule

// File: rtl/sck_divider.sv
module sck_divider
  import sck_divider_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic          bypassEn,
  input  logic [CW-1:0] periodCnt,
  input  logic [CW-1:0] riseAt,
  input  logic [CW-1:0] fallAt,
  output logic          sckOut,
  output logic          riseStb,
  output logic          fallStb
);

  divCtl_t ctl;
  logic    bypassMode;

  assign bypassMode = runEn && bypassEn;

  sck_divider_ctl #(.CW(CW)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .bypassEn  (bypassEn),
    .periodCnt (periodCnt),
    .riseAt    (riseAt),
    .fallAt    (fallAt),
    .ctl       (ctl)
  );

  sck_divider_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .bypassMode (bypassMode),
    .ctl        (ctl),
    .sckOut     (sckOut),
    .riseStb    (riseStb),
    .fallStb    (fallStb)
  );

endmodule

// File: rtl/sck_divider_chk.sv
module sck_divider_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          runEn,
  input logic          bypassEn,
  input logic [CW-1:0] periodCnt,
  input logic          sckOut,
  input logic          riseStb,
  input logic          fallStb
);

  logic bypassMode;
  assign bypassMode = runEn && bypassEn;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bypassMode |-> !(riseStb && fallStb));

  // R4
  rise_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassMode && riseStb) |-> sckOut);

  // R4
  fall_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassMode && fallStb) |-> !sckOut);

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassMode && riseStb) |=> (!riseStb || (runEn && bypassEn)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> ((runEn && bypassEn) || (!sckOut && !riseStb && !fallStb)));

  // R8
  bypass_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    bypassMode |-> (riseStb && fallStb));

endmodule

bind sck_divider sck_divider_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .runEn     (runEn),
  .bypassEn  (bypassEn),
  .periodCnt (periodCnt),
  .sckOut    (sckOut),
  .riseStb   (riseStb),
  .fallStb   (fallStb)
);

// File: tb/sck_divider_bench.sv
module sck_divider_bench;

  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runEn = 1'b0;
  logic          bypassEn = 1'b0;
  logic [CW-1:0] periodCnt = '0;
  logic [CW-1:0] riseAt = '0;
  logic [CW-1:0] fallAt = '0;
  logic          sckOut;
  logic          riseStb;
  logic          fallStb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  int mCnt = 0;
  bit mSck = 0;
  bit mRise = 0;
  bit mFall = 0;

  always #10 clk = ~clk;

  sck_divider #(.CW(CW)) u_sck_divider (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .bypassEn  (bypassEn),
    .periodCnt (periodCnt),
    .riseAt    (riseAt),
    .fallAt    (fallAt),
    .sckOut    (sckOut),
    .riseStb   (riseStb),
    .fallStb   (fallStb)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance the reference one edge with the applied inputs
  task automatic modelEdge();
    bit hr;
    bit hf;
    bit nxt;
    if (!runEn || bypassEn) begin
      mCnt = 0; mSck = 0; mRise = 0; mFall = 0;
    end else begin
      hr = (mCnt == int'(riseAt));
      hf = (mCnt == int'(fallAt));
      nxt = (hr && hf) ? !mSck : hr ? 1'b1 : hf ? 1'b0 : mSck;
      mRise = nxt && !mSck;
      mFall = !nxt && mSck;
      mSck = nxt;
      mCnt = (mCnt == int'(periodCnt)) ? 0 : mCnt + 1;
    end
  endtask

  // one edge, then compare away from it
  task automatic stepCheck();
    string tag;
    @(posedge clk);
    modelEdge();
    #5;
    if (!runEn) tag = "R7";
    else if (riseAt == fallAt) tag = "R5";
    else if (riseAt > periodCnt || fallAt > periodCnt) tag = "R6";
    else tag = "R3";
    check(tag, "sckOut", int'(sckOut), int'(mSck));
    check("R4", "riseStb", int'(riseStb), int'(mRise));
    check("R4", "fallStb", int'(fallStb), int'(mFall));
  endtask

  // measure cycles between two rise strobes
  task automatic measurePeriod(input string req, input int p, input int r, input int f, input int exp);
    int first;
    int second;
    runEn = 0;
    repeat (2) stepCheck();
    periodCnt = CW'(p); riseAt = CW'(r); fallAt = CW'(f);
    runEn = 1;
    first = -1; second = -1;
    for (int k = 0; k < 4 * (p + 1) + 4; k++) begin
      stepCheck();
      if (riseStb) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    check(req, "serial period", second - first, exp);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #5;
    // R1 reset state
    check("R1", "sckOut at reset", int'(sckOut), 0);
    check("R1", "riseStb at reset", int'(riseStb), 0);
    check("R1", "fallStb at reset", int'(fallStb), 0);
    rstN = 1;
    repeat (2) stepCheck();

    // full sweep over small settings, each run restarting from idle (R7)
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 8; r++) begin
        for (int f = 0; f < 8; f++) begin
          runEn = 0;
          periodCnt = CW'(p); riseAt = CW'(r); fallAt = CW'(f);
          repeat (2) stepCheck();
          runEn = 1;
          for (int k = 0; k < 2 * (p + 1) + 3 + ((r * 3 + f) % 5); k++) stepCheck();
        end
      end
    end

    // R2 period of the serial clock with distinct points
    measurePeriod("R2", 5, 1, 4, 6);
    measurePeriod("R2", 1, 0, 1, 2);
    measurePeriod("R2", 63, 31, 63, 64);
    // R5 equal points double the period
    measurePeriod("R5", 3, 2, 2, 8);

    // R7 stop mid-period, restart: first high point at count 2 appears after three edges
    runEn = 0;
    stepCheck();
    periodCnt = CW'(7); riseAt = CW'(2); fallAt = CW'(6);
    runEn = 1;
    repeat (5) stepCheck();
    runEn = 0;
    stepCheck();
    check("R7", "count parked, sck low", int'(sckOut), 0);
    runEn = 1;
    stepCheck(); stepCheck();
    check("R7", "no rise before count 2", int'(sckOut), 0);
    stepCheck();
    check("R7", "rise at count 2 after restart", int'(riseStb), 1);

    // R8 bypass
    bypassEn = 1;
    runEn = 1;
    @(posedge clk); modelEdge(); #5;
    check("R8", "bypass sck high phase", int'(sckOut), 1);
    check("R8", "bypass riseStb", int'(riseStb), 1);
    check("R8", "bypass fallStb", int'(fallStb), 1);
    #10;
    check("R8", "bypass sck low phase", int'(sckOut), 0);
    runEn = 0;
    @(posedge clk); modelEdge(); #5;
    check("R8", "bypass idle sck", int'(sckOut), 0);
    check("R8", "bypass idle riseStb", int'(riseStb), 0);
    bypassEn = 0;
    repeat (2) stepCheck();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule